// File: doc/BRIEF.md
# Serial Flash Status Register with Protection Lock

This block keeps the eight-bit status byte of a serial flash device and applies the rules under which that byte may change. It holds a busy flag and a write-enable latch, two block-protect bits, a flag for auto-increment programming and a lock bit that freezes the protection settings. The command decoder reports each completed instruction to it as a one-cycle strobe. The program and erase engine sets and clears the busy, write-enable and auto-increment flags through its own strobes. The block also turns the two block-protect bits into a protected flag for any address of the array.

A status write only takes effect when the instruction that completed just before it was the arming command. A small two-state machine tracks this. In `ARM_IDLE`, the arming strobe moves it to `ARM_READY`. In `ARM_READY`, another arming strobe keeps it there. A status-write strobe commits the write and returns to `ARM_IDLE`. Any other instruction strobe returns to `ARM_IDLE` and discards the arming. When no strobe arrives, the state holds. Each committed write is then checked against the write-protect pin and the lock bit, both sampled on the same edge as the strobe. That edge corresponds to chip-enable rising at the end of the write instruction.

The status byte is driven continuously, so a read instruction can shift it out at any time, including while busy, and for as long as the host keeps clocking.

Top module: `stat_reg_ctl`

## Requirements
- R1: After reset the status byte reads 0Ch: both protect bits 1 and every other bit 0.
- R2: The status byte layout is: bit 0 busy, bit 1 write-enable latch, bit 2 protect bit P0, bit 3 protect bit P1, bit 6 auto-increment, bit 7 lock. Bits 5:4 always read 0. The output shows a change from the clock edge that samples the strobe causing it.
- R3: A status write is applied only if the instruction completed immediately before it was the arming command. An arming command followed by any other instruction is discarded.
- R4: While the write-protect pin is low and the lock bit is 1, a committed status write changes nothing.
- R5: While the write-protect pin is high, a committed status write loads the lock bit from data bit 7, P1 from data bit 3 and P0 from data bit 2. This includes clearing the lock bit.
- R6: While the write-protect pin is low and the lock bit is 0, one write may set the lock bit and change P1 and P0 together.
- R7: A status write never changes the busy, write-enable or auto-increment bits. Data bits 0, 1, 4, 5 and 6 are ignored.
- R8: The write-enable strobe sets the write-enable latch. The write-disable strobe clears both the latch and the auto-increment bit. The engine's latch-clear strobe clears the latch. A clear wins over a set on the same edge.
- R9: Busy and auto-increment follow the engine's set and clear strobes, and a clear wins over a set on the same edge.
- R10: With an address width of W bits, protect code P1:P0 = 00 marks no address. Code 01 marks addresses at or above 3/4 of 2^W, code 10 marks addresses at or above half, and code 11 marks every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low reset |
| wp_n_i | input | 1 | Write-protect pin, low enables the lock |
| arm_stb_i | input | 1 | Arming command completed |
| wrsr_stb_i | input | 1 | Status-write command completed |
| wrsr_data_i | input | 8 | Data byte of the status write |
| wren_stb_i | input | 1 | Write-enable command completed |
| wrdi_stb_i | input | 1 | Write-disable command completed |
| other_stb_i | input | 1 | Any other instruction completed |
| busy_set_i | input | 1 | Engine: operation started |
| busy_clr_i | input | 1 | Engine: operation finished |
| aai_set_i | input | 1 | Engine: auto-increment mode entered |
| aai_clr_i | input | 1 | Engine: auto-increment mode left |
| wel_clr_i | input | 1 | Engine: clear write-enable latch |
| addr_i | input | ADDR_W | Address to classify |
| prot_o | output | 1 | Address lies in the protected range |
| status_o | output | 8 | Status byte |

## Verification
The bench builds the block with the default 17-bit address width. With that width, the protected bounds land on 18000h and 10000h, and the bench probes the addresses just below and at each bound. The reference model tracks the arming state and the lock rules behaviourally and is compared on every clock. This covers double arming, arming that an intervening instruction discards, lock set and refusal with the pin low, lock clearing with the pin high, and engine strobes that collide on one edge.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [0:0] {
        ARM_IDLE  = 1'b0,
        ARM_READY = 1'b1
    } arm_state_t;

    localparam int SR_BUSY = 0;
    localparam int SR_WEL  = 1;
    localparam int SR_BP0  = 2;
    localparam int SR_BP1  = 3;
    localparam int SR_AAI  = 6;
    localparam int SR_BPL  = 7;

    localparam logic [1:0] BP_NONE    = 2'b00;
    localparam logic [1:0] BP_QUARTER = 2'b01;
    localparam logic [1:0] BP_HALF    = 2'b10;
    localparam logic [1:0] BP_ALL     = 2'b11;

endpackage

// File: rtl/sr_arm_fsm.sv
module sr_arm_fsm
    import sr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic arm_i,
    input  logic wrsr_i,
    input  logic other_i,
    output logic commit_o,
    output logic armed_o
);

    arm_state_t state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ARM_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: begin
                if (arm_i) state_d = ARM_READY;
            end
            ARM_READY: begin
                if (arm_i)                 state_d = ARM_READY;
                else if (wrsr_i || other_i) state_d = ARM_IDLE;
            end
            default: state_d = ARM_IDLE;
        endcase
    end

    always_comb begin
        commit_o = 1'b0;
        armed_o  = 1'b0;
        unique case (state_q)
            ARM_IDLE:  armed_o = 1'b0;
            ARM_READY: begin
                armed_o  = 1'b1;
                commit_o = wrsr_i;
            end
            default: commit_o = 1'b0;
        endcase
    end

    // R3
    disarm_after_other_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (other_i || wrsr_i) && !arm_i |=> !armed_o);

    // R3
    arm_sets_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        arm_i |=> armed_o);

endmodule

// File: rtl/sr_prot_dec.sv
module sr_prot_dec
    import sr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);

    localparam int TOP_BITS = 2;

    logic top_half;
    logic top_quarter;

    generate
        if (ADDR_W >= TOP_BITS) begin : g_wide
            logic [TOP_BITS-1:0] hi;
            assign hi          = addr_i[ADDR_W-1 -: TOP_BITS];
            assign top_half    = hi[1];
            assign top_quarter = &hi;
        end else begin : g_narrow
            assign top_half    = addr_i[ADDR_W-1];
            assign top_quarter = addr_i[ADDR_W-1];
        end
    endgenerate

    always_comb begin
        unique case (bp_i)
            BP_NONE:    prot_o = 1'b0;
            BP_QUARTER: prot_o = top_quarter;
            BP_HALF:    prot_o = top_half;
            BP_ALL:     prot_o = 1'b1;
            default:    prot_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/stat_reg_ctl.sv
module stat_reg_ctl
    import sr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wp_n_i,
    input  logic              arm_stb_i,
    input  logic              wrsr_stb_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              wren_stb_i,
    input  logic              wrdi_stb_i,
    input  logic              other_stb_i,
    input  logic              busy_set_i,
    input  logic              busy_clr_i,
    input  logic              aai_set_i,
    input  logic              aai_clr_i,
    input  logic              wel_clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o,
    output logic [7:0]        status_o
);

    logic       busy_q, wel_q, aai_q, bpl_q;
    logic [1:0] bp_q;
    logic       commit, armed, locked, accept, non_status_instr;

    assign non_status_instr = wren_stb_i | wrdi_stb_i | other_stb_i;

    sr_arm_fsm u_arm (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .arm_i    (arm_stb_i),
        .wrsr_i   (wrsr_stb_i),
        .other_i  (non_status_instr),
        .commit_o (commit),
        .armed_o  (armed)
    );

    assign locked = !wp_n_i && bpl_q;
    assign accept = commit && !locked;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            bpl_q <= 1'b0;
            bp_q  <= BP_ALL;
        end else if (accept) begin
            bpl_q <= wrsr_data_i[SR_BPL];
            bp_q  <= {wrsr_data_i[SR_BP1], wrsr_data_i[SR_BP0]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            busy_q <= 1'b0;
            wel_q  <= 1'b0;
            aai_q  <= 1'b0;
        end else begin
            if (busy_clr_i)                   busy_q <= 1'b0;
            else if (busy_set_i)              busy_q <= 1'b1;
            if (wel_clr_i || wrdi_stb_i)      wel_q  <= 1'b0;
            else if (wren_stb_i)              wel_q  <= 1'b1;
            if (aai_clr_i || wrdi_stb_i)      aai_q  <= 1'b0;
            else if (aai_set_i)               aai_q  <= 1'b1;
        end
    end

    always_comb begin
        status_o          = 8'h00;
        status_o[SR_BUSY] = busy_q;
        status_o[SR_WEL]  = wel_q;
        status_o[SR_BP0]  = bp_q[0];
        status_o[SR_BP1]  = bp_q[1];
        status_o[SR_AAI]  = aai_q;
        status_o[SR_BPL]  = bpl_q;
    end

    sr_prot_dec #(.ADDR_W(ADDR_W)) u_prot (
        .bp_i   (bp_q),
        .addr_i (addr_i),
        .prot_o (prot_o)
    );

    // R3 input contract: one instruction completes per cycle
    one_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0({arm_stb_i, wrsr_stb_i, wren_stb_i, wrdi_stb_i, other_stb_i}));

    // R1
    reset_value_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_n_i) |-> status_o == 8'h0C);

    // R4
    lock_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!wp_n_i && status_o[SR_BPL]) |=> status_o[SR_BPL] && $stable(status_o[SR_BP1:SR_BP0]));

    // R3
    unarmed_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wrsr_stb_i && !armed) |=> $stable({status_o[SR_BPL], status_o[SR_BP1:SR_BP0]}));

    // R7
    wr_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wrsr_stb_i && wrsr_data_i[SR_BUSY] && !status_o[SR_BUSY] && !busy_set_i) |=> !status_o[SR_BUSY]);

    // R7
    wr_no_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wrsr_stb_i && wrsr_data_i[SR_WEL] && !status_o[SR_WEL]) |=> !status_o[SR_WEL]);

    // R7
    wr_no_aai_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wrsr_stb_i && (wrsr_data_i[SR_AAI] || (|wrsr_data_i[5:4])) && !status_o[SR_AAI] && !aai_set_i)
        |=> !status_o[SR_AAI] && status_o[5:4] == 2'b00);

    // R8
    wren_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wren_stb_i && !wel_clr_i) |=> status_o[SR_WEL]);

    // R9
    busy_clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (busy_set_i && busy_clr_i) |=> !status_o[SR_BUSY]);

    // R10
    prot_all_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (status_o[SR_BP1:SR_BP0] == BP_ALL) |-> prot_o);

    // R10
    prot_none_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (status_o[SR_BP1:SR_BP0] == BP_NONE) |-> !prot_o);

endmodule

// File: tb/tb_stat_reg_ctl.sv
module tb_stat_reg_ctl;

    localparam int ADDR_W = 17;
    localparam int SPAN   = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic arm = 0, wrsr = 0, wren = 0, wrdi = 0, other = 0;
    logic bset = 0, bclr = 0, aset = 0, aclr = 0, wclr = 0;
    logic [7:0] wdata = 8'h00;
    logic [ADDR_W-1:0] addr = '0;
    logic prot;
    logic [7:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    string req = "R1";

    int m_busy, m_wel, m_aai, m_bpl, m_bp, m_armed;

    always #2 clk = ~clk;

    stat_reg_ctl #(.ADDR_W(ADDR_W)) dut (
        .clk_i(clk), .rst_n_i(rst_n), .wp_n_i(wp_n),
        .arm_stb_i(arm), .wrsr_stb_i(wrsr), .wrsr_data_i(wdata),
        .wren_stb_i(wren), .wrdi_stb_i(wrdi), .other_stb_i(other),
        .busy_set_i(bset), .busy_clr_i(bclr), .aai_set_i(aset),
        .aai_clr_i(aclr), .wel_clr_i(wclr), .addr_i(addr),
        .prot_o(prot), .status_o(status)
    );

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = 8'h00;
        s[0] = m_busy[0]; s[1] = m_wel[0]; s[2] = m_bp[0]; s[3] = m_bp[1];
        s[6] = m_aai[0];  s[7] = m_bpl[0];
        return s;
    endfunction

    function automatic logic exp_prot();
        int a;
        a = int'(addr);
        case (m_bp)
            0: return 1'b0;
            1: return a >= (SPAN / 4) * 3;
            2: return a >= SPAN / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic model_reset();
        m_busy = 0; m_wel = 0; m_aai = 0; m_bpl = 0; m_bp = 3; m_armed = 0;
    endtask

    task automatic model_update();
        if (wrsr && m_armed != 0 && !(wp_n == 1'b0 && m_bpl == 1)) begin
            m_bpl = int'(wdata[7]);
            m_bp  = int'(wdata[3]) * 2 + int'(wdata[2]);
        end
        if (bclr) m_busy = 0; else if (bset) m_busy = 1;
        if (wclr || wrdi) m_wel = 0; else if (wren) m_wel = 1;
        if (aclr || wrdi) m_aai = 0; else if (aset) m_aai = 1;
        if (arm) m_armed = 1;
        else if (wrsr || wren || wrdi || other) m_armed = 0;
    endtask

    task automatic compare();
        n_checks++;
        if (status !== exp_status()) begin
            n_fail++;
            $display("FAIL %s status actual=%02h expected=%02h", req, status, exp_status());
        end
        n_checks++;
        if (prot !== exp_prot()) begin
            n_fail++;
            $display("FAIL %s prot addr=%05h actual=%0b expected=%0b", req, addr, prot, exp_prot());
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        arm = 0; wrsr = 0; wren = 0; wrdi = 0; other = 0;
        bset = 0; bclr = 0; aset = 0; aclr = 0; wclr = 0;
        @(negedge clk);
        compare();
    endtask

    task automatic do_arm();   arm = 1; step(); endtask
    task automatic do_other(); other = 1; step(); endtask
    task automatic do_wrsr(input logic [7:0] d); wrsr = 1; wdata = d; step(); endtask
    task automatic armed_write(input logic [7:0] d); do_arm(); do_wrsr(d); endtask
    task automatic probe(input int a); addr = a[ADDR_W-1:0]; step(); endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = "R1"; compare();
        step();

        req = "R3";
        do_wrsr(8'h00);
        do_arm(); do_other(); do_wrsr(8'h00);
        do_arm(); wren = 1; step(); do_wrsr(8'h00);
        do_arm(); do_arm(); do_wrsr(8'h08);

        req = "R5"; wp_n = 1'b1;
        armed_write(8'h00);
        req = "R10";
        probe('h1FFFF); probe('h00000);
        req = "R5"; armed_write(8'h04);
        req = "R10";
        probe('h17FFF); probe('h18000); probe('h1FFFF);
        req = "R5"; armed_write(8'h08);
        req = "R10";
        probe('h0FFFF); probe('h10000);

        req = "R6"; wp_n = 1'b0;
        armed_write(8'h8C);
        req = "R4";
        armed_write(8'h00);
        armed_write(8'h84);
        req = "R10"; probe('h00000);

        req = "R5"; wp_n = 1'b1;
        armed_write(8'h00);
        req = "R7";
        armed_write(8'hF3);
        armed_write(8'h00);

        req = "R8";
        wren = 1; step();
        wrdi = 1; step();
        wren = 1; wclr = 1; step();
        wren = 1; step();
        wclr = 1; step();
        wren = 1; step(); aset = 1; step();
        wrdi = 1; step();

        req = "R9";
        bset = 1; step();
        req = "R2"; step(); step();
        armed_write(8'h0C);
        req = "R9";
        bclr = 1; step();
        bset = 1; bclr = 1; step();
        aset = 1; step(); aset = 1; aclr = 1; step();
        aclr = 1; step();

        req = "R2";
        wp_n = 1'b0; armed_write(8'hFF);
        step();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule